// File: doc/BRIEF.md
# Prescaled PWM Generator with 10-bit Duty

This block drives a pulse-width-modulated output from an 8-bit timer. A fine counter runs below the timer. It splits each timer step into four fine slots, so the duty setting has 10 bits on an 8-bit timer. The timer counts up to a programmable period value, then returns to zero. At that return the output goes high. It goes low again when the 10-bit position, made of the timer value with the two fine-slot bits below it, reaches the duty value.

Software programs the period, the 8 high bits and 2 low bits of the duty, the prescale ratio, the timer enable and a pin-direction bit. The duty value and the prescale ratio are copied into shadow registers only at a period boundary. A write made partway through a period therefore cannot cut a pulse short or stretch it. The output and its enable reach the pin only while the direction bit selects output. All pins are plain control and status pins, and no pin carries a data stream, so the block has no handshake.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the timer reads 0, the output is low and the shadow duty is 0, so the output stays low until the first period boundary.
- R2: While enabled, the timer advances by one at the end of each timer step. When a step ends with the timer greater than or equal to the period input, the timer returns to 0 instead. That return is the period boundary.
- R3: A timer step lasts 4 clocks for prescale code 2'b00, 16 clocks for code 2'b01 and 64 clocks for codes 2'b10 and 2'b11. Each step has four fine slots of equal length.
- R4: The duty value and the prescale code come into effect only at a period boundary. The output can rise only when the timer reads 0.
- R5: Within a period the output is high while the 10-bit position {timer, fine slot} is below the shadow duty {duty_msb_i, duty_lsb_i}, and low from the first slot where the position reaches the duty.
- R6: A shadow duty of 0 keeps the output low for the whole period.
- R7: A shadow duty of 4*(period+1) or more keeps the output high for the whole period.
- R8: When dir_in_i is 1, pwm_oe_o is 0 and pwm_o is 0. When dir_in_i is 0, pwm_oe_o is 1 and pwm_o follows the waveform.
- R9: While tmr_en_i is 0, the timer, the fine counter and the output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en_i | input | 1 | Timer enable |
| ps_sel_i | input | 2 | Prescale code: 00 = 1, 01 = 4, 1x = 16 |
| period_i | input | 8 | Period register: last timer value of a period |
| duty_msb_i | input | 8 | Upper 8 bits of the duty |
| duty_lsb_i | input | 2 | Lower 2 bits of the duty (fine slots) |
| dir_in_i | input | 1 | Pin direction: 1 = input, 0 = output |
| pwm_o | output | 1 | PWM waveform, held low while the pin is an input |
| pwm_oe_o | output | 1 | Pin output enable |
| tmr_o | output | 8 | Current timer value |

## Verification
The period boundary and a duty or prescale write can fall in the same cycle. A write can also land partway through a period, just before the boundary that should pick it up. Random stimulus rewrites the duty, the prescale code and the period at random clocks during a segment. A cycle-accurate bench model then judges each cycle: a new duty must shape only the period that follows the next boundary. An assertion confirms that the output never rises away from timer value 0.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int unsigned PS_LOG_MAX = 4;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10
  } ps_sel_e;

  // number of fine-counter bits added on top of the slot bits
  function automatic int unsigned ps_shift(input logic [1:0] sel);
    case (sel)
      PS_DIV1: return 0;
      PS_DIV4: return 2;
      default: return PS_LOG_MAX;
    endcase
  endfunction
endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler
  import pwm10_pkg::*;
#(
  parameter int unsigned FINE_W = 2,
  localparam int unsigned FRAC_W = FINE_W + PS_LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        sel,
  output logic              step,
  output logic [FINE_W-1:0] fine_nxt
);
  logic [FRAC_W-1:0] frac_q, frac_d, lim;
  int unsigned       sh;

  always_comb begin
    sh       = ps_shift(sel);
    lim      = FRAC_W'((1 << (FINE_W + sh)) - 1);
    step     = en && (frac_q >= lim);
    if (!en)       frac_d = frac_q;
    else if (step) frac_d = '0;
    else           frac_d = frac_q + 1'b1;
    fine_nxt = FINE_W'(frac_d >> sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [TMR_W-1:0] period,
  output logic [TMR_W-1:0] tmr_q,
  output logic [TMR_W-1:0] tmr_nxt,
  output logic             wrap
);
  always_comb begin
    wrap = step && (tmr_q >= period);
    if (!step)     tmr_nxt = tmr_q;
    else if (wrap) tmr_nxt = '0;
    else           tmr_nxt = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_nxt;
  end
endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FINE_W = 2,
  localparam int unsigned DW    = TMR_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrap,
  input  logic [DW-1:0]     duty_new,
  input  logic [1:0]        sel_new,
  input  logic [TMR_W-1:0]  tmr_nxt,
  input  logic [FINE_W-1:0] fine_nxt,
  output logic [DW-1:0]     duty_sh,
  output logic [1:0]        sel_sh,
  output logic              pwm_q
);
  logic [DW-1:0] sh_d;
  logic [1:0]    sel_d;
  logic          pwm_d;

  always_comb begin
    sh_d  = wrap ? duty_new : duty_sh;
    sel_d = wrap ? sel_new : sel_sh;
    pwm_d = {tmr_nxt, fine_nxt} < sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh <= '0;
      sel_sh  <= '0;
      pwm_q   <= 1'b0;
    end else if (en) begin
      duty_sh <= sh_d;
      sel_sh  <= sel_d;
      pwm_q   <= pwm_d;
    end
  end
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en_i,
  input  logic [1:0]        ps_sel_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [TMR_W-1:0]  duty_msb_i,
  input  logic [FINE_W-1:0] duty_lsb_i,
  input  logic              dir_in_i,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic [TMR_W-1:0]  tmr_o
);
  localparam int unsigned DW = TMR_W + FINE_W;

  logic              step, wrap, pwm_q;
  logic [FINE_W-1:0] fine_nxt;
  logic [TMR_W-1:0]  tmr_q, tmr_nxt;
  logic [DW-1:0]     duty_sh;
  logic [1:0]        sel_sh;

  pwm10_prescaler #(.FINE_W(FINE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(tmr_en_i), .sel(sel_sh),
    .step(step), .fine_nxt(fine_nxt)
  );

  pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .step(step), .period(period_i),
    .tmr_q(tmr_q), .tmr_nxt(tmr_nxt), .wrap(wrap)
  );

  pwm10_duty #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .en(tmr_en_i), .wrap(wrap),
    .duty_new({duty_msb_i, duty_lsb_i}), .sel_new(ps_sel_i),
    .tmr_nxt(tmr_nxt), .fine_nxt(fine_nxt),
    .duty_sh(duty_sh), .sel_sh(sel_sh), .pwm_q(pwm_q)
  );

  assign tmr_o    = tmr_q;
  assign pwm_oe_o = ~dir_in_i;
  assign pwm_o    = pwm_q & ~dir_in_i;
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int unsigned TMR_W = 8,
  parameter int unsigned DW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_en_i,
  input logic             dir_in_i,
  input logic             pwm_o,
  input logic             pwm_oe_o,
  input logic [TMR_W-1:0] tmr_o,
  input logic             pwm_q,
  input logic [DW-1:0]    duty_sh
);
  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_o != $past(tmr_o)) |-> (tmr_o == '0 || tmr_o == $past(tmr_o) + 1'b1));

  // R4
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> (tmr_o == '0));

  // R6
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_sh == '0) |-> !pwm_q);

  // R8
  pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in_i |-> (!pwm_oe_o && !pwm_o));

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en_i |=> $stable(tmr_o));
endmodule

bind pwm10_gen pwm10_chk #(.TMR_W(TMR_W), .DW(TMR_W + FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en_i(tmr_en_i), .dir_in_i(dir_in_i),
  .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .tmr_o(tmr_o),
  .pwm_q(pwm_q), .duty_sh(duty_sh)
);

// File: tb/pwm10_gen_tb.sv
module pwm10_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] per = 8'd0;
  logic [7:0] dmsb = 8'd0;
  logic [1:0] dlsb = 2'd0;
  logic       dir = 1'b0;
  logic       pwm, oe;
  logic [7:0] tmr;

  int tests = 0;
  int fails = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  pwm10_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en_i(en), .ps_sel_i(sel),
    .period_i(per), .duty_msb_i(dmsb), .duty_lsb_i(dlsb),
    .dir_in_i(dir), .pwm_o(pwm), .pwm_oe_o(oe), .tmr_o(tmr)
  );

  function automatic int shift_of(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b01) ? 2 : 4;
  endfunction

  // reference model built from the requirements
  int       m_frac, m_tmr, m_sh;
  logic [1:0] m_sel;
  bit       m_pwm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frac = 0; m_tmr = 0; m_sh = 0; m_sel = 2'b00; m_pwm = 0;
    end else if (en) begin
      int lim;
      bit stp, wr;
      lim = (4 << shift_of(m_sel)) - 1;
      stp = (m_frac >= lim);
      wr  = stp && (m_tmr >= per);
      m_frac = stp ? 0 : m_frac + 1;
      if (stp) m_tmr = wr ? 0 : m_tmr + 1;
      if (wr) begin
        m_sh  = {dmsb, dlsb};
        m_sel = sel;
      end
      m_pwm = ((m_tmr * 4) + ((m_frac >> shift_of(m_sel)) & 3)) < m_sh;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit exp_pwm;
      exp_pwm = dir ? 1'b0 : m_pwm;
      tests++;
      if (tmr != m_tmr[7:0]) begin
        fails++;
        $display("FAIL R2/R3 timer: got %0d expected %0d", tmr, m_tmr);
      end
      tests++;
      if (pwm != exp_pwm) begin
        fails++;
        $display("FAIL R5/R4 pwm_o: got %0b expected %0b (t=%0t)", pwm, exp_pwm, $time);
      end
      tests++;
      if (oe != !dir) begin
        fails++;
        $display("FAIL R8 pwm_oe_o: got %0b expected %0b", oe, !dir);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h;
    void'($urandom(1234));
    tick(3);
    // R1 reset state
    check("R1 tmr_o", tmr, 0);
    check("R1 pwm_o", pwm, 0);
    rst_n = 1'b1;
    tick(1);
    model_on = 1'b1;

    // directed: period 3, ratio 4 -> 64 clocks per period
    per = 8'd3; sel = 2'b01; en = 1'b1;
    dmsb = 8'd1; dlsb = 2'd1;                 // duty 5
    tick(3 * 64 + 8);
    count_high(128, h);
    check("R5 high clocks duty 5", h, 2 * 5 * 4);
    dmsb = 8'd0; dlsb = 2'd0;                 // R6
    tick(3 * 64);
    count_high(128, h);
    check("R6 high clocks duty 0", h, 0);
    dmsb = 8'd5; dlsb = 2'd0;                 // duty 20 > 16, R7
    tick(3 * 64);
    count_high(128, h);
    check("R7 high clocks duty over period", h, 128);
    // R3 ratio 1: period 3 -> 16 clocks, duty 6
    sel = 2'b00; dmsb = 8'd1; dlsb = 2'd2;
    tick(3 * 64);
    count_high(64, h);
    check("R3 ratio1 high clocks", h, 4 * 6);
    // R8 pin as input
    dir = 1'b1;
    tick(1);
    count_high(40, h);
    check("R8 pwm_o low as input", h, 0);
    check("R8 pwm_oe_o", oe, 0);
    dir = 1'b0;
    // R9 disable freezes timer
    tick(5);
    en = 1'b0;
    tick(1);
    begin
      int t0;
      t0 = tmr;
      tick(50);
      check("R9 timer frozen", tmr, t0);
    end
    en = 1'b1;

    // random segments with mid-period writes
    for (int seg = 0; seg < 60; seg++) begin
      per  = 8'($urandom_range(0, 15));
      sel  = 2'($urandom_range(0, 3));
      dmsb = 8'($urandom_range(0, 18));
      dlsb = 2'($urandom_range(0, 3));
      dir  = ($urandom_range(0, 9) == 0);
      for (int k = 0; k < 6; k++) begin
        tick($urandom_range(5, 120));
        if ($urandom_range(0, 2) == 0) begin
          dmsb = 8'($urandom_range(0, 18));
          dlsb = 2'($urandom_range(0, 3));
        end
        if ($urandom_range(0, 5) == 0) sel = 2'($urandom_range(0, 3));
        en = ($urandom_range(0, 7) != 0);
      end
      en = 1'b1;
    end
    tick(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule